// File: doc/BRIEF.md
# Table-Driven Offset QPSK Pulse-Shaping Modulator

This block turns a fixed-rate stream of two-bit symbols into shaped in-phase and quadrature baseband samples, without any multipliers. Each symbol carries one bit for each rail. Every rail keeps a short record of its most recent bits. A sub-symbol phase counter steps through the sample instants of the current symbol. The shape number, the bit record and the phase index are joined to form the address of a constant sample table. Each table word already holds the sum of all the shaped pulse tails that overlap at that instant, so every output sample costs exactly one registered table read.

The modulator produces one sample per clock, at several samples per symbol. It never stalls. Once per symbol it raises a one-cycle ready strobe. A source that has a symbol must present it during that cycle. If no symbol is presented, the last bit of each rail is repeated and a one-cycle underrun flag is raised. The quadrature rail takes its new bit half a symbol after the in-phase rail, which gives the offset behaviour in which the two rails never change on the same clock edge. A shape-select input picks one of several stored pulse shapes. The choice is sampled only at symbol boundaries.

Top module: `oqpsk_lut_mod`

## Requirements
- R1: With the default 2 phase bits, `sym_ready` is high for exactly one clock in every four. That clock is the last sample instant of the in-phase symbol (in-phase phase index 3). The first strobe comes in the fourth clock after reset is released, and the pattern is the same whether or not symbols arrive.
- R2: At the clock edge that ends a `sym_ready` cycle, the in-phase record shifts in a new bit at position 0 (newest), and older bits move toward position N-1. The quadrature bit accepted at that same edge is shifted into the quadrature record two clocks later, at the edge that ends in-phase phase index 1. No other edge changes either record.
- R3: `samp_i` in a given cycle equals the table word for the in-phase shape, record and phase that were held in the previous cycle (one-cycle latency). That word is the sum over j = 0..N-1 of s(bit j) * p[4j + phase], where bit value 0 maps to s = +1 and bit value 1 maps to s = -1. The result is a signed two's-complement 10-bit value.
- R4: `samp_q` follows the same rule as R3 using the quadrature shape and record. Its phase index is the in-phase phase index plus 2, modulo 4.
- R5: Pulse shape s has taps p_s[k] = 24 * min(k+1, L-k, L >> (s+1)) for k = 0..L-1, with L = 4N and default N = 4. Shape 0 is therefore a triangle peaking at 192. Shape 1 is a trapezoid with its top clipped at 96.
- R6: `shape_sel` is sampled only at the edge that ends a `sym_ready` cycle, and at that edge it becomes the in-phase shape. The quadrature rail adopts that shape at its own boundary two clocks later. Changes to `shape_sel` at any other time have no effect on either output.
- R7: If `sym_valid` is low during a `sym_ready` cycle, each rail shifts in a repeat of its own newest bit. `underrun` is then high for exactly the following clock. `underrun` is never high at any other time.
- R8: While reset is held, and until the first symbol changes a record, both records are all zeros and the shape is 0. At reset the in-phase phase index is 0, so `samp_i` is 432 and `samp_q` (phase index 2) is 432.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one output sample per rail per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | A symbol is presented in this cycle |
| sym_i_bit | input | 1 | In-phase bit of the presented symbol |
| sym_q_bit | input | 1 | Quadrature bit of the presented symbol |
| shape_sel | input | SHAPE_BITS | Pulse shape requested for following symbols |
| sym_ready | output | 1 | One-cycle strobe: symbol is taken at the end of this cycle |
| underrun | output | 1 | One-cycle flag: the last boundary had no symbol |
| samp_i | output | W | Registered signed in-phase sample |
| samp_q | output | W | Registered signed quadrature sample |

## Verification
A wrong bit in either record shows up on that rail's sample in the very next clock. Because each bit contributes to N symbols of samples, the error persists for up to N symbols, so a per-cycle comparison against a direct convolution catches it at once. A slipped phase counter moves the `sym_ready` strobe and rotates the sample sequence, and this is visible within four clocks. A shape latched at the wrong moment, or a quadrature shift on the in-phase edge, produces a mismatch on the first affected sample.

// File: rtl/oqpsk_lut_pkg.sv
package oqpsk_lut_pkg;

   // Tap k of pulse shape s: amp * min(k+1, len-k, len >> (s+1)).
   function automatic int pulse_tap(input int shape, input int k, input int len, input int amp);
      int m;
      int cap;
      m = k + 1;
      if (len - k < m) m = len - k;
      cap = len >> (shape + 1);
      if (cap < m) m = cap;
      return amp * m;
   endfunction

   // Table word for address {shape, history, phase}: signed sum of shaped bits.
   function automatic int table_entry(input int addr, input int hist_depth,
                                      input int phase_bits, input int amp);
      int sps;
      int len;
      int ph;
      int hist;
      int shape;
      int acc;
      int t;
      sps   = 1 << phase_bits;
      len   = hist_depth * sps;
      ph    = addr & (sps - 1);
      hist  = (addr >> phase_bits) & ((1 << hist_depth) - 1);
      shape = addr >> (phase_bits + hist_depth);
      acc   = 0;
      for (int j = 0; j < hist_depth; j++) begin
         t = pulse_tap(shape, j * sps + ph, len, amp);
         if (((hist >> j) & 1) != 0) acc = acc - t;
         else                        acc = acc + t;
      end
      return acc;
   endfunction

   // Largest magnitude any table word can reach, over all shapes and phases.
   function automatic int peak_sum(input int hist_depth, input int phase_bits,
                                   input int shape_bits, input int amp);
      int sps;
      int len;
      int best;
      int acc;
      sps  = 1 << phase_bits;
      len  = hist_depth * sps;
      best = 0;
      for (int s = 0; s < (1 << shape_bits); s++) begin
         for (int ph = 0; ph < sps; ph++) begin
            acc = 0;
            for (int j = 0; j < hist_depth; j++) acc = acc + pulse_tap(s, j * sps + ph, len, amp);
            if (acc > best) best = acc;
         end
      end
      return best;
   endfunction

endpackage

// File: rtl/oqpsk_sym_timing.sv
module oqpsk_sym_timing #(
   parameter int PHASE_BITS = 2,
   parameter int SHAPE_BITS = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sym_valid,
   input  logic                  sym_i,
   input  logic                  sym_q,
   input  logic [SHAPE_BITS-1:0] shape_sel,
   input  logic                  last_i,
   input  logic                  last_q,
   output logic                  ready,
   output logic                  adv_i,
   output logic                  adv_q,
   output logic                  bit_in_i,
   output logic                  bit_in_q,
   output logic [PHASE_BITS-1:0] phase_i,
   output logic [PHASE_BITS-1:0] phase_q,
   output logic [SHAPE_BITS-1:0] shape_i,
   output logic [SHAPE_BITS-1:0] shape_q,
   output logic                  underrun
);
   localparam int SPS = 1 << PHASE_BITS;
   localparam logic [PHASE_BITS-1:0] LAST_PH = PHASE_BITS'(SPS - 1);
   localparam logic [PHASE_BITS-1:0] Q_BND   = PHASE_BITS'(SPS / 2 - 1);
   localparam logic [PHASE_BITS-1:0] Q_OFS   = PHASE_BITS'(SPS / 2);

   logic [PHASE_BITS-1:0] phase_r;
   logic                  pend_q;

   assign ready    = (phase_r == LAST_PH);
   assign adv_i    = ready;
   assign adv_q    = (phase_r == Q_BND);
   assign bit_in_i = sym_valid ? sym_i : last_i;
   assign bit_in_q = pend_q;
   assign phase_i  = phase_r;
   assign phase_q  = phase_r + Q_OFS;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_r  <= '0;
         pend_q   <= 1'b0;
         shape_i  <= '0;
         shape_q  <= '0;
         underrun <= 1'b0;
      end else begin
         phase_r  <= phase_r + 1'b1;
         underrun <= ready & ~sym_valid;
         if (ready) begin
            pend_q  <= sym_valid ? sym_q : last_q;
            shape_i <= shape_sel;
         end
         if (adv_q) shape_q <= shape_i;
      end
   end
endmodule

// File: rtl/oqpsk_rail_hist.sv
module oqpsk_rail_hist #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   input  logic         bit_in,
   output logic [N-1:0] hist
);
   if (N == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   hist <= '0;
         else if (adv) hist <= bit_in;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   hist <= '0;
         else if (adv) hist <= {hist[N-2:0], bit_in};
      end
   end
endmodule

// File: rtl/oqpsk_shape_rom.sv
module oqpsk_shape_rom
   import oqpsk_lut_pkg::*;
#(
   parameter int N          = 4,
   parameter int PHASE_BITS = 2,
   parameter int SHAPE_BITS = 1,
   parameter int W          = 10,
   parameter int AMP        = 24,
   parameter int RST_ADDR   = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [SHAPE_BITS-1:0] shape,
   input  logic [N-1:0]          hist,
   input  logic [PHASE_BITS-1:0] phase,
   output logic signed [W-1:0]   sample
);
   localparam int AW      = SHAPE_BITS + N + PHASE_BITS;
   localparam int DEPTH   = 1 << AW;
   localparam int RST_VAL = table_entry(RST_ADDR, N, PHASE_BITS, AMP);

   logic signed [W-1:0] tbl [DEPTH];
   logic [AW-1:0]       addr;

   for (genvar a = 0; a < DEPTH; a++) begin : g_entry
      localparam int VAL = table_entry(a, N, PHASE_BITS, AMP);
      assign tbl[a] = W'(VAL);
   end

   assign addr = {shape, hist, phase};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sample <= W'(RST_VAL);
      else        sample <= tbl[addr];
   end
endmodule

// File: rtl/oqpsk_lut_mod.sv
module oqpsk_lut_mod
   import oqpsk_lut_pkg::*;
#(
   parameter int HIST_DEPTH = 4,
   parameter int PHASE_BITS = 2,
   parameter int SHAPE_BITS = 1,
   parameter int W          = 10,
   parameter int AMP        = 24,
   parameter int MAX_AW     = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sym_valid,
   input  logic                  sym_i_bit,
   input  logic                  sym_q_bit,
   input  logic [SHAPE_BITS-1:0] shape_sel,
   output logic                  sym_ready,
   output logic                  underrun,
   output logic signed [W-1:0]   samp_i,
   output logic signed [W-1:0]   samp_q
);
   localparam int SPS     = 1 << PHASE_BITS;
   localparam int TAP_LEN = HIST_DEPTH * SPS;
   localparam int PEAK    = peak_sum(HIST_DEPTH, PHASE_BITS, SHAPE_BITS, AMP);

   if (HIST_DEPTH + PHASE_BITS + SHAPE_BITS > MAX_AW) begin : g_chk_depth
      $error("sample table exceeds the allowed address width");
   end
   if (PHASE_BITS < 1 || SHAPE_BITS < 1 || HIST_DEPTH < 1) begin : g_chk_min
      $error("phase, shape and history widths must each be at least one");
   end
   if ((TAP_LEN >> (1 << SHAPE_BITS)) < 1) begin : g_chk_cap
      $error("pulse too short for the number of stored shapes");
   end
   if (PEAK > (1 << (W - 1)) - 1) begin : g_chk_range
      $error("table words overflow the sample width");
   end

   logic                  rail_adv   [2];
   logic                  rail_bit   [2];
   logic                  rail_last  [2];
   logic [HIST_DEPTH-1:0] rail_hist  [2];
   logic [PHASE_BITS-1:0] rail_phase [2];
   logic [SHAPE_BITS-1:0] rail_shape [2];
   logic signed [W-1:0]   rail_samp  [2];

   oqpsk_sym_timing #(
      .PHASE_BITS(PHASE_BITS),
      .SHAPE_BITS(SHAPE_BITS)
   ) timing_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .sym_valid(sym_valid),
      .sym_i    (sym_i_bit),
      .sym_q    (sym_q_bit),
      .shape_sel(shape_sel),
      .last_i   (rail_last[0]),
      .last_q   (rail_last[1]),
      .ready    (sym_ready),
      .adv_i    (rail_adv[0]),
      .adv_q    (rail_adv[1]),
      .bit_in_i (rail_bit[0]),
      .bit_in_q (rail_bit[1]),
      .phase_i  (rail_phase[0]),
      .phase_q  (rail_phase[1]),
      .shape_i  (rail_shape[0]),
      .shape_q  (rail_shape[1]),
      .underrun (underrun)
   );

   for (genvar r = 0; r < 2; r++) begin : g_rail
      assign rail_last[r] = rail_hist[r][0];

      oqpsk_rail_hist #(.N(HIST_DEPTH)) hist_i (
         .clk   (clk),
         .rst_n (rst_n),
         .adv   (rail_adv[r]),
         .bit_in(rail_bit[r]),
         .hist  (rail_hist[r])
      );

      oqpsk_shape_rom #(
         .N         (HIST_DEPTH),
         .PHASE_BITS(PHASE_BITS),
         .SHAPE_BITS(SHAPE_BITS),
         .W         (W),
         .AMP       (AMP),
         .RST_ADDR  ((r == 0) ? 0 : SPS / 2)
      ) rom_i (
         .clk   (clk),
         .rst_n (rst_n),
         .shape (rail_shape[r]),
         .hist  (rail_hist[r]),
         .phase (rail_phase[r]),
         .sample(rail_samp[r])
      );
   end

   assign samp_i = rail_samp[0];
   assign samp_q = rail_samp[1];
endmodule

// File: rtl/oqpsk_lut_mod_chk.sv
module oqpsk_lut_mod_chk #(
   parameter int HIST_DEPTH = 4,
   parameter int PHASE_BITS = 2,
   parameter int SHAPE_BITS = 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  ready,
   input logic                  sym_valid,
   input logic                  underrun,
   input logic [HIST_DEPTH-1:0] hist_i,
   input logic [HIST_DEPTH-1:0] hist_q,
   input logic [SHAPE_BITS-1:0] shape_i
);
   localparam int SPS = 1 << PHASE_BITS;
   logic [7:0] gap_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               gap_cnt <= '0;
      else if (ready)           gap_cnt <= '0;
      else if (gap_cnt != 8'hFF) gap_cnt <= gap_cnt + 1'b1;
   end

   AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ready |=> !ready); // R1
   AST_READY_GAP: assert property (@(posedge clk) disable iff (!rst_n) int'(gap_cnt) < SPS); // R1
   AST_HIST_I_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$past(ready) |-> $stable(hist_i)); // R2
   AST_HIST_Q_APART: assert property (@(posedge clk) disable iff (!rst_n) $past(ready) |-> $stable(hist_q)); // R2
   AST_SHAPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$past(ready) |-> $stable(shape_i)); // R6
   AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) underrun |-> $past(ready && !sym_valid)); // R7
endmodule

bind oqpsk_lut_mod oqpsk_lut_mod_chk #(
   .HIST_DEPTH(HIST_DEPTH),
   .PHASE_BITS(PHASE_BITS),
   .SHAPE_BITS(SHAPE_BITS)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .ready    (sym_ready),
   .sym_valid(sym_valid),
   .underrun (underrun),
   .hist_i   (rail_hist[0]),
   .hist_q   (rail_hist[1]),
   .shape_i  (rail_shape[0])
);

// File: tb/oqpsk_lut_mod_tb_top.sv
`timescale 1ns/1ps
module oqpsk_lut_mod_tb_top;
   localparam int N = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sym_valid = 1'b0;
   logic              sym_i_bit = 1'b0;
   logic              sym_q_bit = 1'b0;
   logic [0:0]        shape_sel = 1'b0;
   logic              sym_ready;
   logic              underrun;
   logic signed [9:0] samp_i;
   logic signed [9:0] samp_q;

   int n_cmp  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   oqpsk_lut_mod dut_i (
      .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_i_bit(sym_i_bit),
      .sym_q_bit(sym_q_bit), .shape_sel(shape_sel), .sym_ready(sym_ready),
      .underrun(underrun), .samp_i(samp_i), .samp_q(samp_q)
   );

   // Pulse taps and convolution taken from R5 and R3.
   function automatic int ref_tap(int s, int k);
      int m;
      int cap;
      m = k + 1;
      if (16 - k < m) m = 16 - k;
      cap = 16 >> (s + 1);
      if (cap < m) m = cap;
      return 24 * m;
   endfunction

   function automatic int ref_conv(int s, logic [N-1:0] h, int ph);
      int acc;
      acc = 0;
      for (int j = 0; j < N; j++) begin
         if (h[j]) acc -= ref_tap(s, 4 * j + ph);
         else      acc += ref_tap(s, 4 * j + ph);
      end
      return acc;
   endfunction

   task automatic check(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Reference state built from R1, R2, R4, R6, R7.
   logic [N-1:0] m_hist_i = '0;
   logic [N-1:0] m_hist_q = '0;
   int  m_ph = 0;
   int  m_sh_i = 0;
   int  m_sh_q = 0;
   bit  m_pend = 1'b0;
   bit  m_und = 1'b0;
   int  q_i[$];
   int  q_q[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_hist_i = '0; m_hist_q = '0; m_ph = 0; m_sh_i = 0; m_sh_q = 0;
         m_pend = 1'b0; m_und = 1'b0;
         q_i.delete(); q_q.delete();
      end else begin
         q_i.push_back(ref_conv(m_sh_i, m_hist_i, m_ph));             // R3
         q_q.push_back(ref_conv(m_sh_q, m_hist_q, (m_ph + 2) % 4));   // R4
         m_und = (m_ph == 3) && !sym_valid;                            // R7
         if (m_ph == 3) begin                                          // R2 in-phase edge
            m_hist_i = {m_hist_i[N-2:0], sym_valid ? sym_i_bit : m_hist_i[0]};
            m_pend   = sym_valid ? sym_q_bit : m_hist_q[0];
            m_sh_i   = int'(shape_sel);                                // R6
         end
         if (m_ph == 1) begin                                          // R2 quadrature edge
            m_hist_q = {m_hist_q[N-2:0], m_pend};
            m_sh_q   = m_sh_i;
         end
         m_ph = (m_ph + 1) % 4;
      end
   end

   // Monitor: compare every registered sample and the strobes.
   always @(negedge clk) begin
      if (rst_n && q_i.size() > 0) begin
         check("R3 in-phase sample (history R2, shape R5 R6)", int'(samp_i), q_i.pop_front());
         check("R4 quadrature sample (offset R2, shape R5 R6)", int'(samp_q), q_q.pop_front());
         check("R1 sym_ready", int'(sym_ready), int'(m_ph == 3));
         check("R7 underrun", int'(underrun), int'(m_und));
      end
   end

   task automatic send_sym(bit vld, bit bi, bit bq);
      @(negedge clk);
      while (!sym_ready) @(negedge clk);
      sym_valid = vld; sym_i_bit = bi; sym_q_bit = bq;
      @(negedge clk);
      sym_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R8 reset samp_i", int'(samp_i), 432);
      check("R8 reset samp_q", int'(samp_q), 432);
      check("R8 reset sym_ready", int'(sym_ready), 0);
      check("R8 reset underrun", int'(underrun), 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);                    // idle: R7 underruns on zeros
      send_sym(1, 0, 0); send_sym(1, 1, 0); send_sym(1, 0, 1); send_sym(1, 1, 1);
      for (int k = 0; k < 5; k++) send_sym(1, 1, 1); // full negative peak, R3 R4
      // R6: shape_sel pulsed between boundaries must not matter.
      @(negedge clk); shape_sel = 1'b1; @(negedge clk); shape_sel = 1'b0;
      for (int k = 0; k < 3; k++) send_sym(1, 0, 1);
      shape_sel = 1'b1;                              // R5 second shape
      for (int k = 0; k < 6; k++) send_sym(1, k[0], k[1]);
      send_sym(0, 0, 0); send_sym(0, 0, 0);          // R7 repeat last bits
      for (int k = 0; k < 80; k++) begin
         send_sym(($urandom % 6) != 0, 1'($urandom), 1'($urandom));
         if (($urandom % 4) == 0) shape_sel = ~shape_sel;
      end
      repeat (8) @(negedge clk);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_fail++;
         $display("FAIL R1 watchdog: actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
         $finish;
      end
   end
endmodule